// File: doc/BRIEF.md
# Completion Ring Producer with Threshold Interrupt

This block keeps the producer side of two completion rings that live in host memory: a transmit ring (ring 0) and a receive ring (ring 1). For every accepted completion request it works out the host byte address where the entry goes and issues a one-cycle DMA write request. It then advances that ring's producer index by the entry's size in 32-bit words. The host reports how far it has read by writing a consumer index. The block derives the occupied and free word counts from the two indices, holds off new requests that do not fit, and sets a sticky interrupt status bit when a programmable threshold is crossed.

A shared-ring mode sends receive completions into the transmit ring. Each such entry is cut to at most two words, and the receive ring is left idle. The entry size of each ring is picked by a type code. The ring length is picked by a size code. Entries never straddle the end of a ring: an entry that would run past the end is placed at offset zero, and the skipped tail counts as used.

Top module: `cpl_queue_producer`

## Requirements
- R1: After synchronous reset all configuration fields, both producer and consumer indices and both interrupt bits are zero, `dma_valid` is low, and `cpl_ready` is high.
- R2: The ring control register (`reg_addr[2:1]`=0; `reg_addr[0]` selects the ring, 0 = transmit, 1 = receive) holds the type code in bits 5:4. Type 00 is a 1-word entry, 01 and 10 are 2-word entries, and 11 is a 4-word entry. `dma_words` reports this size, and the producer index (counted in words) advances by it.
- R3: Control bits 31:8 give the ring base. `dma_addr` equals base×256 plus four times the entry's starting word offset.
- R4: Mode register (`reg_addr[2:1]`=1) bits 1:0 set the ring length: 00 = 1024 words, 01 = 2048 words, 10 or 11 = 4096 words, all scaled by `RING_MIN_BYTES`/4096. An entry whose end would pass the ring end starts at offset 0. An entry ending exactly at the ring end wraps the index to 0.
- R5: The valid count is (producer − consumer) mod ring length and the free count is length − 1 − valid. The consumer index is written at `reg_addr[2:1]`=2. `cpl_ready` is low whenever the free count is below the words the request needs, including any skipped tail.
- R6: Control bits 3:0 hold a threshold T. With mode bit 2 at 0, the ring's interrupt bit sets when free ≤ 4·T.
- R7: With mode bit 2 at 1, the interrupt bit sets when valid ≥ 4·T.
- R8: An interrupt bit stays set until its ring's mode register is written with bit 8 set. That write clears it, and the bit may set again from the next cycle on.
- R9: A producer index write (`reg_addr[2:1]`=3) takes effect only while control bit 6 of that ring is 1. Otherwise it leaves the index unchanged.
- R10: When mode bit 3 of either ring is 1 (shared mode), a receive request is written into the transmit ring with size min(receive type size, 2). The receive ring's index does not move, and its interrupt bit does not set.
- R11: Control bit 7 of the target ring drives `dma_wide64` with the request.
- R12: `dma_valid` is high for exactly the cycle after each accepted request (`cpl_valid` and `cpl_ready` both high) and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Bit 0 ring select, bits 2:1 register select |
| reg_wdata | input | 32 | Register write data |
| cpl_valid | input | 1 | Completion request present |
| cpl_rx | input | 1 | Request is a receive completion |
| cpl_ready | output | 1 | Request fits in its target ring |
| dma_valid | output | 1 | DMA write request strobe |
| dma_addr | output | 32 | Host byte address of the entry |
| dma_words | output | 3 | Entry size in 32-bit words |
| dma_wide64 | output | 1 | Use 64-bit addressing |
| irq_status | output | 2 | Sticky threshold interrupt bits, one per ring |

## Verification
The bench sweeps every type and size code until the ring stalls, then drains and refills it across the end. A design that let an entry straddle the end, or that counted a full ring as empty, would show a wrong address or a ready that stays high. Every threshold value is checked in both modes at every fill level of a 16-word ring, where an off-by-one comparison or a missing factor of four flips the interrupt. A mixed run in shared mode, with moving consumer indices, catches missing size caps and receive entries leaking onto the wrong ring. Dedicated checks confirm that a locked producer write leaves the address sequence intact and that the interrupt bit stays set after its condition goes away.

// File: rtl/cq_pkg.sv
package cq_pkg;
  // words per completion entry for a type code
  function automatic logic [2:0] entry_words(input logic [1:0] code);
    case (code)
      2'b00:   return 3'd1;
      2'b11:   return 3'd4;
      default: return 3'd2;
    endcase
  endfunction
endpackage

// File: rtl/cq_ring.sv
module cq_ring #(
  parameter int MIN_WORDS = 1024,
  localparam int IDXW = $clog2(MIN_WORDS * 4),
  localparam int CW = IDXW + 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [1:0]      wr_fn,
  input  logic [31:0]     wr_data,
  input  logic            active,
  input  logic [2:0]      req_words,
  input  logic            take,
  output logic            fit,
  output logic [IDXW-1:0] start_off,
  output logic [23:0]     base,
  output logic            wide64,
  output logic [1:0]      etype,
  output logic            common,
  output logic            irq
);
  logic [23:0]     base_q;
  logic            wide_q, pwe_q, tmode_q, common_q, irq_q;
  logic [1:0]      type_q, size_q;
  logic [3:0]      thr_q;
  logic [IDXW-1:0] prod_q, cons_q;

  logic [CW-1:0]   ring_w, p_x, need, sum, thr_eff;
  logic [IDXW-1:0] mask, p, c, valid, empty, next;
  logic            wrap, cond, clr;

  always_comb begin
    case (size_q)
      2'b00:   ring_w = CW'(MIN_WORDS);
      2'b01:   ring_w = CW'(MIN_WORDS * 2);
      default: ring_w = CW'(MIN_WORDS * 4);
    endcase
    mask  = IDXW'(ring_w - CW'(1));
    p     = prod_q & mask;
    c     = cons_q & mask;
    valid = (p - c) & mask;
    empty = mask - valid;
    p_x   = CW'(p);
    wrap  = (p_x + CW'(req_words)) > ring_w;
    need  = CW'(req_words) + (wrap ? (ring_w - p_x) : CW'(0));
    fit   = CW'(empty) >= need;
    start_off = wrap ? '0 : p;
    sum   = CW'(start_off) + CW'(req_words);
    next  = sum[IDXW-1:0] & mask;
    thr_eff = CW'({thr_q, 2'b00});
    cond  = active && (tmode_q ? (CW'(valid) >= thr_eff) : (CW'(empty) <= thr_eff));
    clr   = wr_en && (wr_fn == 2'd1) && wr_data[8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0; wide_q <= 1'b0; pwe_q <= 1'b0; type_q <= '0; thr_q <= '0;
      size_q <= '0; tmode_q <= 1'b0; common_q <= 1'b0;
      prod_q <= '0; cons_q <= '0; irq_q <= 1'b0;
    end else begin
      if (wr_en && wr_fn == 2'd0) begin
        base_q <= wr_data[31:8];
        wide_q <= wr_data[7];
        pwe_q  <= wr_data[6];
        type_q <= wr_data[5:4];
        thr_q  <= wr_data[3:0];
      end
      if (wr_en && wr_fn == 2'd1) begin
        size_q   <= wr_data[1:0];
        tmode_q  <= wr_data[2];
        common_q <= wr_data[3];
      end
      if (wr_en && wr_fn == 2'd2) cons_q <= wr_data[IDXW-1:0];
      if (wr_en && wr_fn == 2'd3 && pwe_q) prod_q <= wr_data[IDXW-1:0];
      else if (take) prod_q <= next;
      irq_q <= clr ? 1'b0 : (irq_q | cond);
    end
  end

  assign base   = base_q;
  assign wide64 = wide_q;
  assign etype  = type_q;
  assign common = common_q;
  assign irq    = irq_q;

  // R5: nothing is taken that does not fit
  assert_take_fits_R5: assert property (@(posedge clk) disable iff (rst) take |-> fit);
  // R2: producer moves by exactly the entry size from the entry start
  assert_advance_R2: assert property (@(posedge clk) disable iff (rst)
    (take && !wr_en) |=> (((prod_q - $past(start_off)) & $past(mask)) ==
                          (IDXW'($past(req_words)) & $past(mask))));
  // R9: locked producer write leaves the index alone
  assert_prod_locked_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_fn == 2'd3 && !pwe_q && !take) |=> $stable(prod_q));
  // R8: sticky until cleared, clear wins
  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !clr) |=> irq_q);
  assert_irq_clear_R8: assert property (@(posedge clk) disable iff (rst)
    clr |=> !irq_q);
endmodule

// File: rtl/cq_dma_req.sv
module cq_dma_req #(
  parameter int IDXW = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fire,
  input  logic [23:0]     base,
  input  logic [IDXW-1:0] start_off,
  input  logic [2:0]      words,
  input  logic            wide64,
  output logic            dma_valid,
  output logic [31:0]     dma_addr,
  output logic [2:0]      dma_words,
  output logic            dma_wide64
);
  logic [31:0] addr_c;
  assign addr_c = {base, 8'h00} + 32'({start_off, 2'b00});

  always_ff @(posedge clk) begin
    if (rst) begin
      dma_valid <= 1'b0; dma_addr <= '0; dma_words <= '0; dma_wide64 <= 1'b0;
    end else begin
      dma_valid <= fire;
      if (fire) begin
        dma_addr   <= addr_c;
        dma_words  <= words;
        dma_wide64 <= wide64;
      end
    end
  end

  // R2: only legal entry sizes are requested
  assert_dma_size_R2: assert property (@(posedge clk) disable iff (rst)
    dma_valid |-> (dma_words == 3'd1 || dma_words == 3'd2 || dma_words == 3'd4));
endmodule

// File: rtl/cpl_queue_producer.sv
module cpl_queue_producer #(
  parameter int RING_MIN_BYTES = 4096
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  input  logic        cpl_valid,
  input  logic        cpl_rx,
  output logic        cpl_ready,
  output logic        dma_valid,
  output logic [31:0] dma_addr,
  output logic [2:0]  dma_words,
  output logic        dma_wide64,
  output logic [1:0]  irq_status
);
  import cq_pkg::*;
  localparam int MIN_WORDS = RING_MIN_BYTES / 4;
  localparam int IDXW = $clog2(MIN_WORDS * 4);

  logic [1:0]      fit_v, wide_v, comm_v, irq_v, take_v, active_v;
  logic [IDXW-1:0] start_v [2];
  logic [23:0]     base_v  [2];
  logic [1:0]      typ_v   [2];
  logic            shared, tgt, accept;
  logic [2:0]      words, rx_full, rx_cap;

  assign shared  = |comm_v;
  assign tgt     = cpl_rx && !shared;
  assign rx_full = entry_words(typ_v[1]);
  assign rx_cap  = (rx_full > 3'd2) ? 3'd2 : rx_full;
  assign words   = (cpl_rx && shared) ? rx_cap : entry_words(typ_v[tgt]);
  assign cpl_ready = fit_v[tgt];
  assign accept  = cpl_valid && cpl_ready;
  assign active_v = {!shared, 1'b1};

  for (genvar r = 0; r < 2; r++) begin : g_ring
    assign take_v[r] = accept && (tgt == 1'(r));
    cq_ring #(.MIN_WORDS(MIN_WORDS)) u_ring (
      .clk(clk), .rst(rst),
      .wr_en(reg_we && (reg_addr[0] == 1'(r))),
      .wr_fn(reg_addr[2:1]), .wr_data(reg_wdata),
      .active(active_v[r]), .req_words(words), .take(take_v[r]),
      .fit(fit_v[r]), .start_off(start_v[r]), .base(base_v[r]),
      .wide64(wide_v[r]), .etype(typ_v[r]), .common(comm_v[r]), .irq(irq_v[r])
    );
  end

  cq_dma_req #(.IDXW(IDXW)) u_dma (
    .clk(clk), .rst(rst), .fire(accept),
    .base(base_v[tgt]), .start_off(start_v[tgt]), .words(words), .wide64(wide_v[tgt]),
    .dma_valid(dma_valid), .dma_addr(dma_addr), .dma_words(dma_words), .dma_wide64(dma_wide64)
  );

  assign irq_status = irq_v;

  // R10: receive ring idle in shared mode
  assert_rx_idle_shared_R10: assert property (@(posedge clk) disable iff (rst)
    shared |-> !take_v[1]);
  assert_rx_irq_shared_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(shared) && shared && !$past(irq_v[1])) |-> !irq_v[1]);
  // R12: one request strobe per acceptance
  assert_dma_follows_R12: assert property (@(posedge clk) disable iff (rst)
    accept |=> dma_valid);
  assert_dma_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !dma_valid);
endmodule

// File: tb/cpl_queue_producer_tb.sv
module cpl_queue_producer_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1, reg_we = 0, cpl_valid = 0, cpl_rx = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic cpl_ready, dma_valid, dma_wide64;
  logic [31:0] dma_addr;
  logic [2:0] dma_words;
  logic [1:0] irq_status;

  cpl_queue_producer #(.RING_MIN_BYTES(64)) u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .cpl_valid(cpl_valid), .cpl_rx(cpl_rx), .cpl_ready(cpl_ready),
    .dma_valid(dma_valid), .dma_addr(dma_addr), .dma_words(dma_words),
    .dma_wide64(dma_wide64), .irq_status(irq_status));

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  int mp[2], mc[2], msize[2], mtype[2], mbase[2], mwide[2], mpwe[2], mcom[2];
  int unsigned seed = 32'h1d2c3b4a;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int ew(input int t);
    return (t == 0) ? 1 : ((t == 3) ? 4 : 2);
  endfunction
  function automatic int rlen(input int s);
    return 16 << ((s >= 2) ? 2 : s);
  endfunction
  function automatic int rnd(input int n);
    seed = seed * 1103515245 + 12345;
    return int'((seed >> 8) % n);
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    reg_we = 1; reg_addr = 3'(a); reg_wdata = d;
    tick();
    reg_we = 0;
  endtask

  task automatic set_ctrl(input int r, input int base, input int wide, input int pwe,
                          input int typ, input int thr);
    wr(r, {24'(base), 1'(wide), 1'(pwe), 2'(typ), 4'(thr)});
    mbase[r] = base; mwide[r] = wide; mpwe[r] = pwe; mtype[r] = typ;
  endtask

  task automatic set_mode(input int r, input int size, input int tmode, input int com,
                          input int clr);
    wr(2 + r, {23'd0, 1'(clr), 4'd0, 1'(com), 1'(tmode), 2'(size)});
    msize[r] = size; mcom[r] = com;
  endtask

  task automatic set_cons(input int r, input int v);
    wr(4 + r, 32'(v)); mc[r] = v % 64;
  endtask

  task automatic set_prod(input int r, input int v);
    wr(6 + r, 32'(v));
    if (mpwe[r] != 0) mp[r] = v % 64;
  endtask

  task automatic complete(input bit rx, output bit took);
    int t, w, rl, p, c, valid, empty, need, start;
    bit sh, wrap, fit;
    sh = (mcom[0] != 0) || (mcom[1] != 0);
    t = (rx && !sh) ? 1 : 0;
    w = (rx && sh) ? ((ew(mtype[1]) > 2) ? 2 : ew(mtype[1])) : ew(mtype[t]);
    rl = rlen(msize[t]); p = mp[t] % rl; c = mc[t] % rl;
    valid = (p - c + rl) % rl; empty = rl - 1 - valid;
    wrap = (p + w) > rl; need = w + (wrap ? rl - p : 0);
    fit = empty >= need; start = wrap ? 0 : p;
    cpl_valid = 1; cpl_rx = rx; #1;
    chk(cpl_ready == fit, "R5", "ready vs free space", cpl_ready, fit);
    tick();
    cpl_valid = 0;
    took = fit;
    if (fit) begin
      chk(dma_valid == 1'b1, "R12", "strobe after accept", dma_valid, 1);
      chk(dma_addr == 32'(mbase[t] * 256 + start * 4), (wrap ? "R4" : "R3"), "address",
          dma_addr, mbase[t] * 256 + start * 4);
      chk(dma_words == 3'(w), (rx && sh) ? "R10" : "R2", "entry words", dma_words, w);
      chk(dma_wide64 == 1'(mwide[t]), "R11", "64-bit flag", dma_wide64, mwide[t]);
      mp[t] = (start + w) % rl;
    end else begin
      chk(dma_valid == 1'b0, "R12", "no strobe on stall", dma_valid, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit took;
    for (int r = 0; r < 2; r++) begin
      mp[r] = 0; mc[r] = 0; msize[r] = 0; mtype[r] = 0; mbase[r] = 0;
      mwide[r] = 0; mpwe[r] = 0; mcom[r] = 0;
    end
    repeat (3) tick();
    rst = 0;
    // R1 reset state
    chk(dma_valid == 1'b0, "R1", "dma_valid after reset", dma_valid, 0);
    chk(irq_status == 2'b00, "R1", "irq after reset", irq_status, 0);
    chk(cpl_ready == 1'b1, "R1", "ready after reset", cpl_ready, 1);
    complete(1'b0, took);

    // R2 R3 R4 R5: every type and size, fill to stall, drain, wrap
    for (int s = 0; s < 3; s++) begin
      for (int ty = 0; ty < 4; ty++) begin
        set_ctrl(0, 24'h3A5000 + s * 16 + ty, ty & 1, 1, ty, 0);
        set_mode(0, s, 0, 0, 1);
        set_prod(0, 0); set_cons(0, 0);
        took = 1;
        for (int k = 0; k < 70 && took; k++) complete(1'b0, took);
        chk(took == 1'b0, "R5", "ring reaches stall", took, 0);
        set_cons(0, mp[0]);
        for (int k = 0; k < rlen(s) / ew(ty) + 2; k++) complete(1'b0, took);
      end
    end

    // R4: entries that would straddle the end restart at 0 (4-word after 1-word)
    set_ctrl(0, 24'h000100, 0, 1, 3, 0);
    set_ctrl(1, 24'h000200, 1, 1, 0, 0);
    set_mode(0, 0, 0, 1, 1);
    set_prod(0, 14); set_cons(0, 10);
    complete(1'b1, took);
    complete(1'b0, took);

    // R10 shared mode mixed run, then separate rings
    for (int ph = 0; ph < 2; ph++) begin
      set_mode(0, 0, 0, 1 - ph, 1);
      set_mode(1, 1, 0, 0, 1);
      for (int k = 0; k < 200; k++) begin
        if (rnd(4) == 0) set_ctrl(1, 24'h000200, 1, 1, rnd(4), 0);
        if (rnd(3) == 0) set_cons(rnd(2), rnd(64));
        complete(1'(rnd(2)), took);
      end
    end

    // R9: locked producer write is ignored
    set_mode(0, 0, 0, 0, 1);
    set_ctrl(0, 24'h000400, 0, 1, 0, 0);
    set_prod(0, 3); set_cons(0, 3);
    set_ctrl(0, 24'h000400, 0, 0, 0, 0);
    set_prod(0, 9);
    chk(mp[0] == 3, "R9", "model index held", mp[0], 3);
    complete(1'b0, took);

    // R6 R7: all thresholds, both modes, every fill level of a 16-word ring
    for (int tm = 0; tm < 2; tm++) begin
      for (int th = 0; th < 16; th++) begin
        set_ctrl(0, 0, 0, 1, 0, th);
        set_cons(0, 0);
        for (int p = 0; p < 16; p++) begin
          bit exp_irq;
          set_prod(0, p);
          set_mode(0, 0, tm, 0, 1);
          tick();
          exp_irq = (tm == 0) ? ((15 - p) <= 4 * th) : (p >= 4 * th);
          chk(irq_status[0] == exp_irq, (tm == 0) ? "R6" : "R7", "threshold irq",
              irq_status[0], exp_irq);
        end
      end
    end

    // R8: sticky after the condition goes away, cleared by write-one
    set_ctrl(0, 0, 0, 1, 0, 1);
    set_mode(0, 0, 1, 0, 1);
    set_prod(0, 8); tick();
    chk(irq_status[0] == 1'b1, "R8", "irq set", irq_status[0], 1);
    set_prod(0, 0); tick(); tick();
    chk(irq_status[0] == 1'b1, "R8", "irq sticky", irq_status[0], 1);
    set_mode(0, 0, 1, 0, 1); tick();
    chk(irq_status[0] == 1'b0, "R8", "irq cleared", irq_status[0], 0);

    // R10: receive ring interrupt held off in shared mode
    set_ctrl(1, 24'h000200, 0, 1, 0, 0);
    set_mode(0, 0, 1, 1, 1);
    set_mode(1, 0, 1, 0, 1);
    tick(); tick();
    chk(irq_status[1] == 1'b0, "R10", "rx irq off when shared", irq_status[1], 0);
    set_mode(0, 0, 1, 0, 1);
    tick(); tick();
    chk(irq_status[1] == 1'b1, "R10", "rx irq back when not shared", irq_status[1], 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule